// File: doc/BRIEF.md
# Control Frame Permanence Release Unit

This unit sits behind a frame parser on the receive side of a time-triggered Ethernet node. It takes in synchronisation control frames that have already been parsed. It stamps each accepted frame with the local time at which it arrived. The frame is then held until its permanence point: the arrival time, plus the network's configured worst-case transmission delay, minus the delay the frame has already accumulated on its way through transparent-clock switches.

Because each frame carries its own accumulated delay, the order in which frames leave the unit is set by that field and not by their arrival order. A frame that took a slow path is held for a shorter time. As a result, frames leave in the order their senders dispatched them. Downstream clock-correction logic receives one frame per cycle, together with its permanence time.

Frames whose accumulated delay is larger than the configured maximum cannot be placed correctly, so they are discarded and counted. Frames that find every holding slot occupied are also discarded and counted.

Top module: `ctrl_frame_release`

## Requirements
- R1: A frame presented with a type field other than 0x891D is ignored: nothing is stored, nothing is released for it, and the error count does not change.
- R2: An accepted frame's permanence time equals the `localTime` value sampled in its acceptance cycle, plus `MAX_TX_DELAY`, minus the low `TIME_W` bits of its 64-bit transparent-clock value. This value appears on `relPermTime` when the frame is released.
- R3: A held frame is released, with `relValid` high, in the cycle after the first clock edge at which all three of these hold: it is held, it is the first in release order, and `localTime` is greater than or equal to its permanence time.
- R4: Release order is ascending permanence time. A later arrival with a larger accumulated delay therefore leaves before an earlier arrival with a smaller one.
- R5: Two held frames with the same permanence time leave in arrival order.
- R6: A control frame whose full 64-bit transparent-clock value exceeds `MAX_TX_DELAY` is discarded, and `errCount` increases by one. High bits set above `TIME_W` count as an excess.
- R7: A control frame that arrives while all `DEPTH` slots are held is discarded, and `errCount` increases by one. Occupancy is taken before any release in the same cycle.
- R8: At most one frame is released per cycle. Its cycle number, membership vector and 4-bit kind come out unchanged.
- R9: A frame whose transparent-clock value equals `MAX_TX_DELAY` is released in the cycle right after its acceptance edge, provided no frame ahead of it is due.
- R10: After reset no frame is held, `relValid` is low and `errCount` is zero. `errCount` wraps at its width. `localTime` must advance monotonically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| localTime | input | TIME_W | Local time counter in ticks |
| inValid | input | 1 | A parsed frame is present this cycle |
| inEthType | input | 16 | Frame type field |
| inCycle | input | CYC_W | Integration cycle number from the payload |
| inMember | input | MEMB_W | Membership vector from the payload |
| inKind | input | KIND_W | Control frame kind |
| inTransClock | input | TC_W | Accumulated transparent-clock delay, in ticks |
| relValid | output | 1 | A frame is released this cycle |
| relCycle | output | CYC_W | Released cycle number |
| relMember | output | MEMB_W | Released membership vector |
| relKind | output | KIND_W | Released kind |
| relPermTime | output | TIME_W | Permanence time of the released frame |
| errCount | output | ERR_W | Count of discarded control frames |

## Verification
The bench uses the default build: `DEPTH` = 8, `MAX_TX_DELAY` = 40 ticks and `TIME_W` = 32. With a 40-tick hold, the random phase (about one frame in three cycles) regularly keeps more than eight frames in flight. That exercises the full-slot discard path, permanence ties and reordering many times in a few thousand cycles. The small delay limit also lets directed cases cover the exact-limit frame, the one-over frame and a frame with only upper transparent-clock bits set.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  parameter int unsigned TIME_W = 32;
  parameter int unsigned CYC_W  = 32;
  parameter int unsigned MEMB_W = 32;
  parameter int unsigned KIND_W = 4;
  parameter int unsigned TC_W   = 64;
  parameter logic [15:0] CTRL_ETYPE = 16'h891D;

  typedef struct packed {
    logic [CYC_W-1:0]  cyc;
    logic [MEMB_W-1:0] memb;
    logic [KIND_W-1:0] kind;
  } frameInfo_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;
    logic fireEn;
  } strobes_t;
endpackage

// File: rtl/cfr_datapath.sv
module cfr_datapath
  import cfr_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int MAX_TX_DELAY = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] localTime,
  input  frameInfo_t        inInfo,
  input  logic [TC_W-1:0]   inTransClock,
  input  strobes_t          stb,
  output logic              tooLate,
  output logic              full,
  output logic              due,
  output logic              relValid,
  output frameInfo_t        relInfo,
  output logic [TIME_W-1:0] relPermTime
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  // arrival tags only need to span the longest time a frame can stay held
  localparam int SEQ_W = $clog2(MAX_TX_DELAY + DEPTH + 1) + 2;
  localparam logic [TC_W-1:0]   MAX_TC   = TC_W'(MAX_TX_DELAY);
  localparam logic [TIME_W-1:0] MAX_TIME = TIME_W'(MAX_TX_DELAY);

  logic [DEPTH-1:0]  slotValid;
  logic [TIME_W-1:0] slotPerm [DEPTH];
  logic [SEQ_W-1:0]  slotSeq  [DEPTH];
  frameInfo_t        slotInfo [DEPTH];
  logic [SEQ_W-1:0]  nextSeq;
  logic [IDX_W-1:0]  freeIdx;
  logic [IDX_W-1:0]  winIdx;
  logic              winFound;
  logic [TIME_W-1:0] newPerm;

  function automatic logic goesFirst(input logic [TIME_W-1:0] permA,
                                     input logic [SEQ_W-1:0]  seqA,
                                     input logic [TIME_W-1:0] permB,
                                     input logic [SEQ_W-1:0]  seqB);
    logic [SEQ_W-1:0] seqDiff;
    seqDiff = seqA - seqB;
    return (permA < permB) || ((permA == permB) && seqDiff[SEQ_W-1]);
  endfunction

  assign tooLate = inTransClock > MAX_TC;
  assign newPerm = localTime + MAX_TIME - inTransClock[TIME_W-1:0];

  // lowest free slot
  always_comb begin
    freeIdx = '0;
    full    = 1'b1;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slotValid[i]) begin
        freeIdx = IDX_W'(i);
        full    = 1'b0;
      end
    end
  end

  // earliest held frame: smallest permanence time, then oldest arrival
  always_comb begin
    winFound = 1'b0;
    winIdx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (slotValid[i] &&
          (!winFound || goesFirst(slotPerm[i], slotSeq[i], slotPerm[winIdx], slotSeq[winIdx]))) begin
        winFound = 1'b1;
        winIdx   = IDX_W'(i);
      end
    end
  end

  assign due = winFound && (localTime >= slotPerm[winIdx]);

  always_ff @(posedge clk) begin
    if (rst) begin
      slotValid   <= '0;
      nextSeq     <= '0;
      relValid    <= 1'b0;
      relInfo     <= '0;
      relPermTime <= '0;
    end else begin
      relValid <= stb.fireEn;
      if (stb.fireEn) begin
        slotValid[winIdx] <= 1'b0;
        relInfo           <= slotInfo[winIdx];
        relPermTime       <= slotPerm[winIdx];
      end
      if (stb.loadEn) begin
        slotValid[freeIdx] <= 1'b1;
        nextSeq            <= nextSeq + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.loadEn) begin
      slotPerm[freeIdx] <= newPerm;
      slotSeq[freeIdx]  <= nextSeq;
      slotInfo[freeIdx] <= inInfo;
    end
  end

  logic [TIME_W-1:0] prevRelPerm;
  logic              prevRelSeen;
  always_ff @(posedge clk) begin
    if (rst) begin
      prevRelSeen <= 1'b0;
      prevRelPerm <= '0;
    end else if (relValid) begin
      prevRelSeen <= 1'b1;
      prevRelPerm <= relPermTime;
    end
  end

  // R3
  release_not_early_chk: assert property (@(posedge clk) disable iff (rst)
    relValid |-> $past(localTime) >= relPermTime);

  // R4
  release_order_chk: assert property (@(posedge clk) disable iff (rst)
    (relValid && prevRelSeen) |-> relPermTime >= prevRelPerm);

  // R8
  release_from_held_chk: assert property (@(posedge clk) disable iff (rst)
    stb.fireEn |=> relValid && ($countones($past(slotValid)) == $countones(slotValid) + (($past(stb.loadEn)) ? 0 : 1)));
endmodule

// File: rtl/cfr_control.sv
module cfr_control
  import cfr_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [15:0]      inEthType,
  input  logic             tooLate,
  input  logic             full,
  input  logic             due,
  output strobes_t         stb,
  output logic [ERR_W-1:0] errCount
);
  logic isCtrl;
  logic dropNow;

  assign isCtrl  = inValid && (inEthType == CTRL_ETYPE);
  assign dropNow = isCtrl && (tooLate || full);

  always_comb begin
    stb.loadEn = isCtrl && !tooLate && !full;
    stb.fireEn = due;
  end

  always_ff @(posedge clk) begin
    if (rst) errCount <= '0;
    else if (dropNow) errCount <= errCount + 1'b1;
  end

  // R6
  err_step_chk: assert property (@(posedge clk) disable iff (rst)
    (errCount == $past(errCount)) || (errCount == $past(errCount) + 1'b1));

  // R1
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inEthType != CTRL_ETYPE) |=> errCount == $past(errCount));

  // R6
  late_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (isCtrl && tooLate) |=> errCount == $past(errCount) + 1'b1);

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (isCtrl && full) |=> errCount == $past(errCount) + 1'b1);
endmodule

// File: rtl/ctrl_frame_release.sv
module ctrl_frame_release
  import cfr_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int MAX_TX_DELAY = 40,
  parameter int ERR_W        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] localTime,
  input  logic              inValid,
  input  logic [15:0]       inEthType,
  input  logic [CYC_W-1:0]  inCycle,
  input  logic [MEMB_W-1:0] inMember,
  input  logic [KIND_W-1:0] inKind,
  input  logic [TC_W-1:0]   inTransClock,
  output logic              relValid,
  output logic [CYC_W-1:0]  relCycle,
  output logic [MEMB_W-1:0] relMember,
  output logic [KIND_W-1:0] relKind,
  output logic [TIME_W-1:0] relPermTime,
  output logic [ERR_W-1:0]  errCount
);
  frameInfo_t inInfo;
  frameInfo_t relInfo;
  strobes_t   stb;
  logic       tooLate;
  logic       full;
  logic       due;

  assign inInfo.cyc  = inCycle;
  assign inInfo.memb = inMember;
  assign inInfo.kind = inKind;

  cfr_control #(.ERR_W(ERR_W)) u_control (
    .clk(clk), .rst(rst), .inValid(inValid), .inEthType(inEthType),
    .tooLate(tooLate), .full(full), .due(due), .stb(stb), .errCount(errCount)
  );

  cfr_datapath #(.DEPTH(DEPTH), .MAX_TX_DELAY(MAX_TX_DELAY)) u_datapath (
    .clk(clk), .rst(rst), .localTime(localTime), .inInfo(inInfo),
    .inTransClock(inTransClock), .stb(stb), .tooLate(tooLate), .full(full),
    .due(due), .relValid(relValid), .relInfo(relInfo), .relPermTime(relPermTime)
  );

  assign relCycle  = relInfo.cyc;
  assign relMember = relInfo.memb;
  assign relKind   = relInfo.kind;
endmodule

// File: tb/ctrl_frame_release_bench.sv
`timescale 1ns/1ps
module ctrl_frame_release_bench;
  import cfr_pkg::*;
  localparam int DEPTH = 8;
  localparam int MAXD  = 40;
  localparam int ERR_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TIME_W-1:0] localTime = 1000;
  logic              inValid = 1'b0;
  logic [15:0]       inEthType = '0;
  logic [CYC_W-1:0]  inCycle = '0;
  logic [MEMB_W-1:0] inMember = '0;
  logic [KIND_W-1:0] inKind = '0;
  logic [TC_W-1:0]   inTransClock = '0;
  logic              relValid;
  logic [CYC_W-1:0]  relCycle;
  logic [MEMB_W-1:0] relMember;
  logic [KIND_W-1:0] relKind;
  logic [TIME_W-1:0] relPermTime;
  logic [ERR_W-1:0]  errCount;

  always #4 clk = ~clk;

  ctrl_frame_release #(.DEPTH(DEPTH), .MAX_TX_DELAY(MAXD), .ERR_W(ERR_W)) u_ctrl_frame_release (
    .clk(clk), .rst(rst), .localTime(localTime), .inValid(inValid), .inEthType(inEthType),
    .inCycle(inCycle), .inMember(inMember), .inKind(inKind), .inTransClock(inTransClock),
    .relValid(relValid), .relCycle(relCycle), .relMember(relMember), .relKind(relKind),
    .relPermTime(relPermTime), .errCount(errCount)
  );

  int    nTests = 0;
  int    nFail  = 0;
  bit    finished = 0;
  string curReq = "R10";

  // reference model of held frames
  bit                mV    [DEPTH];
  logic [TIME_W-1:0] mPerm [DEPTH];
  int                mSeq  [DEPTH];
  logic [CYC_W-1:0]  mCyc  [DEPTH];
  logic [MEMB_W-1:0] mMemb [DEPTH];
  logic [KIND_W-1:0] mKind [DEPTH];
  int                seqCnt = 0;
  int                expErr = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one cycle: model decides, inputs driven, edge, outputs checked
  task automatic step(input bit v, input logic [15:0] ty, input logic [TC_W-1:0] tc,
                      input logic [CYC_W-1:0] cy, input logic [MEMB_W-1:0] mb,
                      input logic [KIND_W-1:0] kd);
    int occ = 0;
    int best = -1;
    bit expRel = 0;
    logic [CYC_W-1:0]  eCyc = '0;
    logic [MEMB_W-1:0] eMemb = '0;
    logic [KIND_W-1:0] eKind = '0;
    logic [TIME_W-1:0] ePerm = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (mV[i]) begin
        occ++;
        if (best < 0 || mPerm[i] < mPerm[best] ||
            (mPerm[i] == mPerm[best] && mSeq[i] < mSeq[best])) best = i;
      end
    end
    if (best >= 0 && mPerm[best] <= localTime) begin
      expRel = 1; eCyc = mCyc[best]; eMemb = mMemb[best];
      eKind = mKind[best]; ePerm = mPerm[best]; mV[best] = 0;
    end
    if (v && ty == 16'h891D) begin
      if (tc > TC_W'(MAXD) || occ == DEPTH) expErr++;
      else begin
        for (int j = 0; j < DEPTH; j++) begin
          if (!mV[j]) begin
            mV[j] = 1;
            mPerm[j] = localTime + TIME_W'(MAXD) - tc[TIME_W-1:0];
            mSeq[j] = seqCnt; mCyc[j] = cy; mMemb[j] = mb; mKind[j] = kd;
            seqCnt++;
            break;
          end
        end
      end
    end
    inValid = v; inEthType = ty; inTransClock = tc;
    inCycle = cy; inMember = mb; inKind = kd;
    @(posedge clk);
    @(negedge clk);
    check(relValid == expRel, curReq, "relValid", longint'(relValid), longint'(expRel));
    if (expRel && relValid) begin
      check(relPermTime == ePerm, curReq, "relPermTime", longint'(relPermTime), longint'(ePerm));
      check(relCycle == eCyc && relMember == eMemb && relKind == eKind, curReq, "relCycle",
            longint'(relCycle), longint'(eCyc));
    end
    check(errCount == ERR_W'(expErr), curReq, "errCount", longint'(errCount), longint'(expErr));
    inValid = 0;
    localTime = localTime + 1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 16'h0000, '0, '0, '0, '0);
  endtask

  task automatic send(input logic [TC_W-1:0] tc, input logic [CYC_W-1:0] cy);
    step(1, 16'h891D, tc, cy, 32'hA5A5_0000 ^ cy, KIND_W'(cy));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nTests++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R10: reset state
    check(relValid == 1'b0, "R10", "relValid after reset", longint'(relValid), 0);
    check(errCount == '0, "R10", "errCount after reset", longint'(errCount), 0);

    // R1: foreign type frames are ignored
    curReq = "R1";
    step(1, 16'h0800, 64'd3, 32'd7, 32'd7, 4'd1);
    step(1, 16'h891C, 64'd0, 32'd8, 32'd8, 4'd2);
    idle(MAXD + 5);

    // R9: exact-limit delay leaves right away
    curReq = "R9";
    send(64'(MAXD), 32'd11);
    idle(3);

    // R2 and R3: exact permanence time and release cycle
    curReq = "R2";
    send(64'd10, 32'd21);
    curReq = "R3";
    idle(MAXD);

    // R4: a later arrival with more accumulated delay goes first
    curReq = "R4";
    send(64'd0, 32'd31);
    send(64'd30, 32'd32);
    idle(MAXD + 5);

    // R5: equal permanence times keep arrival order
    curReq = "R5";
    send(64'd5, 32'd41);
    send(64'd6, 32'd42);
    send(64'd7, 32'd43);
    idle(MAXD + 5);

    // R6: over-limit delay dropped, including upper-bit-only values
    curReq = "R6";
    send(64'(MAXD + 1), 32'd51);
    send(64'h0000_0001_0000_0000, 32'd52);
    idle(3);

    // R7: overflow of all slots
    curReq = "R7";
    for (int k = 0; k < DEPTH + 3; k++) send(64'd0, 32'(60 + k));
    idle(MAXD + DEPTH + 5);

    // R8: random mix, including bursts
    curReq = "R8";
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom % 16;
      logic [TC_W-1:0] tc;
      if (r == 0) tc = TC_W'(MAXD + 1 + ($urandom % 4));
      else if (r == 1) tc = {32'h1, 32'($urandom % MAXD)};
      else tc = TC_W'($urandom % (MAXD + 1));
      if ($urandom % 3 == 0)
        step(1, ($urandom % 8 == 0) ? 16'h86DD : 16'h891D, tc, $urandom, $urandom, KIND_W'($urandom));
      else
        idle(1);
    end
    idle(MAXD + DEPTH + 5);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule